// File: doc/BRIEF.md
# Request/Reply Input Sorter with Per-Source Credits

This block is the receive stage of a node's network interface. Packets from the network arrive on one input stream. Each packet is either a request or a reply, and the block places it in one of two independent queues. Replies go to a small reply queue that is always able to take them, so a node whose own outbound traffic is blocked still drains the replies it is waiting for. Requests go to a shared request queue. Each remote source may hold at most `SLOTS` requests in that queue at once, and a per-source credit counter tracks this.

A request that arrives after its source has used up its credits is not stalled and is not queued. The block turns it into a NACK that carries the refused packet's source and tag, and places the NACK in a two-entry queue that feeds the network-facing NACK port. The input only stalls when an over-credit request arrives while that NACK queue is full. The local protocol logic takes requests and replies from their own dequeue ports.

Every stream uses valid/ready. A transfer happens on a rising clock edge when valid and ready are both high. A sender that has raised valid keeps valid and all its fields steady until ready is seen. The block's output streams keep valid and their fields steady until they are taken. `in_ready` may depend on `in_is_req` and `in_src` in the same cycle.

Top module: `nrx_input_sorter`

## Requirements
- R1: A reply (`in_is_req`=0) on the input is accepted in the cycle it is presented (`in_ready`=1), and replies leave on the reply port in the order they arrived, with source, tag and data unchanged.
- R2: Requests leave the request port in their overall arrival order across all sources, with source, tag and data unchanged.
- R3: The request queue holds `SLOTS*(NODES-1)` entries (6 by default), and the reply queue holds `SLOTS` entries (2 by default). A reply presented while the reply queue is full is a protocol violation and is flagged by an assertion.
- R4: Each remote source (`in_src` from 0 to `NODES-2`) has `SLOTS` request credits. A credit is spent when a request from that source is queued, and it is returned in the cycle that request is taken from the request port.
- R5: A request that arrives when its source has no credit left is never placed in the request queue. Instead a NACK carrying that packet's `in_src` and `in_tag` is queued for the NACK port.
- R6: The NACK queue holds 2 entries. `in_ready` is low only for an over-credit request that arrives while the NACK queue is full. `nack_valid` and the NACK fields stay steady until `nack_ready` is seen.
- R7: Replies keep being accepted while requests cannot be, that is, while credits are used up and the NACK queue is full.
- R8: After reset all output valids are low, every source has its full credit, and the NACK queue is empty.
- R9: An accepted packet shows up on its output port in the next cycle, not the same cycle. Taking an entry and accepting a new one in the same cycle loses neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Incoming packet can be taken this cycle |
| in_is_req | input | 1 | 1 = request, 0 = reply |
| in_src | input | SRC_W (2) | Remote source index, 0..NODES-2 |
| in_tag | input | TAG_W (4) | Packet tag |
| in_data | input | DATA_W (16) | Packet payload |
| req_valid | output | 1 | Request queue head present |
| req_ready | input | 1 | Local logic takes the request |
| req_src | output | SRC_W (2) | Source of head request |
| req_tag | output | TAG_W (4) | Tag of head request |
| req_data | output | DATA_W (16) | Payload of head request |
| rsp_valid | output | 1 | Reply queue head present |
| rsp_ready | input | 1 | Local logic takes the reply |
| rsp_src | output | SRC_W (2) | Source of head reply |
| rsp_tag | output | TAG_W (4) | Tag of head reply |
| rsp_data | output | DATA_W (16) | Payload of head reply |
| nack_valid | output | 1 | NACK waiting for the network |
| nack_ready | input | 1 | Network takes the NACK |
| nack_src | output | SRC_W (2) | Source of the refused request |
| nack_tag | output | TAG_W (4) | Tag of the refused request |

## Verification
The assertions assume that the input never presents a reply while the reply queue is full, that `in_src` is always a valid remote index below `NODES-1`, and that a stalled input packet is held steady. The stimulus meets all three. The bench's driver offers a reply only when its own model shows room in the reply queue, and it draws sources only from the legal range. After a stall it repeats the same packet until that packet is accepted. Ready on the three output ports is switched at different rates, so that credits run out, NACKs pile up, and the input stall actually happens during the run.

// File: rtl/nrx_pkg.sv
package nrx_pkg;
  localparam int TAG_W_DEF  = 4;
  localparam int DATA_W_DEF = 16;

  typedef enum logic {KIND_REPLY = 1'b0, KIND_REQ = 1'b1} pkt_kind_e;

  function automatic int src_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/nrx_fifo.sv
module nrx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3: storage never written past capacity
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> !full);
  // R9: nothing is taken from an empty queue
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/nrx_credit_bank.sv
module nrx_credit_bank #(
  parameter int NSRC  = 3,
  parameter int SLOTS = 2,
  parameter int SRC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [SRC_W-1:0] take_src,
  input  logic             give,
  input  logic [SRC_W-1:0] give_src,
  output logic [NSRC-1:0]  avail
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [CNT_W-1:0] used;
    logic take_g, give_g;

    assign take_g   = take && (take_src == SRC_W'(g));
    assign give_g   = give && (give_src == SRC_W'(g));
    assign avail[g] = (used < CNT_W'(SLOTS));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                used <= '0;
      else if (take_g && !give_g) used <= used + 1'b1;
      else if (give_g && !take_g) used <= used - 1'b1;
    end

    // R4: a source never holds more than its reserved slots
    p_credit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      used <= CNT_W'(SLOTS));
    // R4: a credit is only returned for a request that spent one
    p_credit_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
      give_g |-> used != '0);
  end
endmodule

// File: rtl/nrx_input_sorter.sv
module nrx_input_sorter
  import nrx_pkg::*;
#(
  parameter int NODES      = 4,
  parameter int SLOTS      = 2,
  parameter int TAG_W      = TAG_W_DEF,
  parameter int DATA_W     = DATA_W_DEF,
  parameter int NACK_DEPTH = 2,
  localparam int NSRC      = NODES - 1,
  localparam int SRC_W     = src_width(NODES - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_is_req,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [SRC_W-1:0]  req_src,
  output logic [TAG_W-1:0]  req_tag,
  output logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [SRC_W-1:0]  rsp_src,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              nack_valid,
  input  logic              nack_ready,
  output logic [SRC_W-1:0]  nack_src,
  output logic [TAG_W-1:0]  nack_tag
);
  localparam int REQ_DEPTH = SLOTS * NSRC;
  localparam int PKT_W     = SRC_W + TAG_W + DATA_W;
  localparam int NK_W      = SRC_W + TAG_W;

  logic [NSRC-1:0] avail;
  logic credit_ok, accept, is_req;
  logic rq_push, rq_pop, rq_empty, rq_full;
  logic rs_push, rs_pop, rs_empty, rs_full;
  logic nk_push, nk_pop, nk_empty, nk_full;
  logic [PKT_W-1:0] in_pkt, rq_head, rs_head;
  logic [NK_W-1:0]  nk_head;

  assign is_req = (in_is_req == KIND_REQ);
  assign in_pkt = {in_src, in_tag, in_data};

  always_comb begin
    credit_ok = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (in_src == SRC_W'(i)) credit_ok = avail[i];
  end

  // Refused requests only stall when the NACK store has no room.
  assign in_ready = is_req ? (credit_ok || !nk_full) : 1'b1;
  assign accept   = in_valid && in_ready;

  assign rq_push = accept && is_req && credit_ok;
  assign nk_push = accept && is_req && !credit_ok;
  assign rs_push = accept && !is_req && !rs_full;

  assign rq_pop = req_valid && req_ready;
  assign rs_pop = rsp_valid && rsp_ready;
  assign nk_pop = nack_valid && nack_ready;

  nrx_credit_bank #(.NSRC(NSRC), .SLOTS(SLOTS), .SRC_W(SRC_W)) u_credit (
    .clk(clk), .rst_n(rst_n),
    .take(rq_push), .take_src(in_src),
    .give(rq_pop),  .give_src(req_src),
    .avail(avail)
  );

  nrx_fifo #(.W(PKT_W), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk(clk), .rst_n(rst_n), .push(rq_push), .din(in_pkt),
    .pop(rq_pop), .dout(rq_head), .empty(rq_empty), .full(rq_full)
  );

  nrx_fifo #(.W(PKT_W), .DEPTH(SLOTS)) u_rsp_q (
    .clk(clk), .rst_n(rst_n), .push(rs_push), .din(in_pkt),
    .pop(rs_pop), .dout(rs_head), .empty(rs_empty), .full(rs_full)
  );

  nrx_fifo #(.W(NK_W), .DEPTH(NACK_DEPTH)) u_nack_q (
    .clk(clk), .rst_n(rst_n), .push(nk_push), .din({in_src, in_tag}),
    .pop(nk_pop), .dout(nk_head), .empty(nk_empty), .full(nk_full)
  );

  assign req_valid = !rq_empty;
  assign {req_src, req_tag, req_data} = rq_head;
  assign rsp_valid = !rs_empty;
  assign {rsp_src, rsp_tag, rsp_data} = rs_head;
  assign nack_valid = !nk_empty;
  assign {nack_src, nack_tag} = nk_head;

  // R3: a reply must never meet a full reply queue (input protocol)
  p_reply_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !is_req |-> !rs_full);
  // R3: credits keep the shared request store from overflowing
  p_req_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rq_push && !rq_pop |-> !rq_full);
  // R1: an accepted reply is visible on the reply port next cycle
  p_reply_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !is_req |=> rsp_valid);
  // R6: a pending NACK is held steady until taken
  p_nack_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nack_valid && !nack_ready |=> nack_valid && $stable(nack_src) && $stable(nack_tag));
  // R5: a refused request never enters the request queue
  p_refuse_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_push && nk_push));
  // R2: sources stay in the legal remote range
  p_src_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> in_src < SRC_W'(NSRC));
endmodule

// File: tb/nrx_input_sorter_bench.sv
module nrx_input_sorter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K = 2;
  localparam int NS = 3;

  typedef struct packed {
    logic [1:0]  src;
    logic [3:0]  tag;
    logic [15:0] data;
  } ent_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_req = 1'b0;
  logic [1:0] in_src = '0;
  logic [3:0] in_tag = '0;
  logic [15:0] in_data = '0;
  logic req_ready = 1'b0, rsp_ready = 1'b0, nack_ready = 1'b0;
  logic in_ready, req_valid, rsp_valid, nack_valid;
  logic [1:0] req_src, rsp_src, nack_src;
  logic [3:0] req_tag, rsp_tag, nack_tag;
  logic [15:0] req_data, rsp_data;

  int checks = 0, errors = 0;
  int n_req_seen = 0, n_nack_seen = 0;
  bit done = 1'b0;

  ent_t mq_req[$], mq_rsp[$], mq_nack[$];
  int mcnt[NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  nrx_input_sorter u_nrx_input_sorter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_req(in_is_req),
    .in_src(in_src), .in_tag(in_tag), .in_data(in_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
    .req_tag(req_tag), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_src(rsp_src),
    .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .nack_valid(nack_valid), .nack_ready(nack_ready),
    .nack_src(nack_src), .nack_tag(nack_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference model: compare the current state, then advance by one edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_rdy, exp_rqv, exp_rsv, exp_nkv, acc, room;
      ent_t pkt;
      exp_rqv = mq_req.size() > 0;
      exp_rsv = mq_rsp.size() > 0;
      exp_nkv = mq_nack.size() > 0;
      room = in_is_req ? (mcnt[in_src] < K) : 1'b1;
      exp_rdy = in_is_req ? (room || mq_nack.size() < 2) : 1'b1;
      if (in_valid)
        chk(in_ready == exp_rdy, in_is_req ? "R6" : "R1", "in_ready", in_ready, exp_rdy);
      chk(req_valid == exp_rqv, "R9", "req_valid", req_valid, exp_rqv);
      if (exp_rqv && req_valid)
        chk({req_src, req_tag, req_data} == mq_req[0], "R2", "req head",
            {req_src, req_tag, req_data}, mq_req[0]);
      chk(rsp_valid == exp_rsv, "R9", "rsp_valid", rsp_valid, exp_rsv);
      if (exp_rsv && rsp_valid)
        chk({rsp_src, rsp_tag, rsp_data} == mq_rsp[0], "R1", "rsp head",
            {rsp_src, rsp_tag, rsp_data}, mq_rsp[0]);
      chk(nack_valid == exp_nkv, "R5", "nack_valid", nack_valid, exp_nkv);
      if (exp_nkv && nack_valid)
        chk({nack_src, nack_tag} == {mq_nack[0].src, mq_nack[0].tag}, "R5", "nack fields",
            {nack_src, nack_tag}, {mq_nack[0].src, mq_nack[0].tag});
      if (req_valid && req_ready) n_req_seen++;
      if (nack_valid && nack_ready) n_nack_seen++;
      // advance, decisions use the state before this edge
      acc = in_valid && exp_rdy;
      pkt = '{src: in_src, tag: in_tag, data: in_data};
      if (exp_rqv && req_ready) begin
        mcnt[mq_req[0].src]--;
        void'(mq_req.pop_front());
      end
      if (exp_rsv && rsp_ready) void'(mq_rsp.pop_front());
      if (exp_nkv && nack_ready) void'(mq_nack.pop_front());
      if (acc) begin
        if (!in_is_req) mq_rsp.push_back(pkt);
        else if (room) begin
          mq_req.push_back(pkt);
          mcnt[pkt.src]++;
        end else mq_nack.push_back(pkt);
      end
    end
  end

  task automatic send(input bit rq, input int s, input int t, input int d, output int waited);
    @(posedge clk); #1;
    in_valid = 1'b1; in_is_req = rq; in_src = 2'(s); in_tag = 4'(t); in_data = 16'(d);
    waited = 0;
    forever begin
      @(negedge clk);
      if (in_ready) break;
      waited++;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int w;
    foreach (mcnt[i]) mcnt[i] = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(!req_valid && !rsp_valid && !nack_valid, "R8", "valids in reset",
        {req_valid, rsp_valid, nack_valid}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    in_is_req = 1'b1; in_src = 2'd2;
    @(negedge clk);
    chk(in_ready == 1'b1 && !nack_valid, "R8", "full credit after reset", in_ready, 1);

    // Use up source 0 credits, then two refusals fill the NACK queue
    send(1, 0, 0, 16'h1000, w);
    send(1, 0, 1, 16'h1001, w);
    send(1, 0, 2, 16'h1002, w);
    send(1, 0, 3, 16'h1003, w);
    chk(w == 0, "R5", "refused request not stalled", w, 0);
    // R7: replies still flow while requests are blocked
    send(0, 1, 5, 16'h2005, w);
    chk(w == 0, "R7", "reply stall cycles", w, 0);
    send(0, 2, 6, 16'h2006, w);
    chk(w == 0, "R3", "second reply fits", w, 0);
    // R6: over-credit request with full NACK queue stalls until a NACK leaves
    fork
      send(1, 0, 4, 16'h1004, w);
      begin
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R6", "stall with full nack queue", in_ready, 0);
        @(posedge clk); #1 nack_ready = 1'b1;
      end
    join
    repeat (4) @(negedge clk);
    chk(n_nack_seen == 3, "R5", "nacks delivered", n_nack_seen, 3);
    chk(n_req_seen == 0, "R5", "no refused request queued", n_req_seen, 0);

    // R3: fill the request queue to its six entries
    send(1, 1, 7, 16'h3007, w);
    send(1, 2, 8, 16'h3008, w);
    send(1, 1, 9, 16'h3009, w);
    send(1, 2, 10, 16'h300a, w);
    chk(w == 0, "R3", "sixth request accepted", w, 0);
    @(posedge clk); #1 req_ready = 1'b1; rsp_ready = 1'b1;
    repeat (10) @(negedge clk);
    chk(n_req_seen == 6, "R3", "requests drained", n_req_seen, 6);
    // R4: credit returned, so source 0 is accepted again
    send(1, 0, 11, 16'h100b, w);
    repeat (3) @(negedge clk);
    chk(n_req_seen == 7 && n_nack_seen == 3, "R4", "credit reuse",
        {n_req_seen, n_nack_seen}, {32'd7, 32'd3});

    // Mixed traffic with varying back-pressure (R1, R2, R4, R5, R6, R9 via model)
    begin
      bit pend;
      pend = 1'b0;
      for (int c = 0; c < 6000; c++) begin
        @(posedge clk); #1;
        if ((c % 500) == 0) begin
          req_ready  = 1'b0; rsp_ready = 1'b0; nack_ready = 1'b0;
        end
        req_ready  = ($urandom_range(0, 9) < (c / 500) % 4 + 2);
        rsp_ready  = ($urandom_range(0, 9) < 5);
        nack_ready = ($urandom_range(0, 9) < (c / 700) % 3 + 1);
        if (!pend) begin
          bit want_req;
          in_valid = ($urandom_range(0, 9) < 8);
          want_req = ($urandom_range(0, 9) < 7);
          // R3: never offer a reply the reply queue cannot hold
          if (!want_req && mq_rsp.size() >= K) want_req = 1'b1;
          in_is_req = want_req;
          in_src  = 2'($urandom_range(0, NS - 1));
          in_tag  = 4'($urandom_range(0, 15));
          in_data = 16'($urandom_range(0, 65535));
        end
        @(negedge clk);
        pend = in_valid && !in_ready;
      end
    end
    @(posedge clk); #1 in_valid = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule